// File: doc/BRIEF.md
# Interrupt Source Crossbar Router

This block routes a wide bank of peripheral interrupt request lines onto a narrower set of interrupt controller inputs. Each routable output owns a select register that holds a source index. The output is a registered copy of the level on the chosen source line. Software programs these registers through a simple write port and reads them back through a combinational read port.

Some outputs are reserved. They have no register, take no address space and are held low. Other outputs are hardwired. Each hardwired output always follows one fixed source line, and writes to its register are ignored. The select registers sit at compacted byte offsets: counting outputs upward, the offset moves forward by one register width for every output that is not reserved. Reset loads a common safe source index into every routable register.

Top module: `irq_route_xbar`

## Requirements
- R1: A routable output drives, one clock after each rising edge, the level that the source line named by its select register had at that edge. Outputs are active-high, and each one is low while reset is asserted.
- R2: Output o's register sits at byte offset REG_BYTES times the number of non-reserved outputs below o. In the default configuration (8 outputs, 2-byte registers, output 2 reserved) the offsets of outputs 0,1,3,4,5,6,7 are 0,2,4,6,8,10,12. A write there with a valid index updates the register, and a read there returns the index zero-extended to 32 bits.
- R3: A reserved output (default: output 2) is always low, whatever the source levels.
- R4: A hardwired output (default: output 5, fixed to source 9) follows its fixed source with one clock of latency. Writes to its offset are ignored, and reads at its offset return the fixed index.
- R5: After reset, every routable register holds SAFE_SRC (default 3).
- R6: The written index is the low REG_BYTES*8 bits of wr_data. If that value is at or above N_SRC, the write is ignored and the register keeps its previous value.
- R7: A read at an offset that belongs to no register returns zero. This covers an offset at or beyond REG_BYTES times the count of non-reserved outputs, and an offset that is not a multiple of REG_BYTES.
- R8: A change on a source line does not reach an output before the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | N_SRC | Peripheral interrupt levels, active-high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | 32 | Write data; the low REG_BYTES*8 bits are the index |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | 32 | Read data, combinational |
| out_irq | output | N_OUT | Routed interrupt levels to the controller |

## Verification
The case that is hardest to reach is proving that each output follows its own register and no other. A fixed source pattern cannot separate a correct route from a crossed one. For each routable output, the bench therefore writes every source index in turn. After each write it drives a one-hot pattern on that source and then its complement. The whole output vector is compared on both patterns, so a wrong address decode or a wrong bit pick shows up on a neighbouring output as well.

// File: rtl/irq_route_xbar.sv
module irq_route_xbar #(
  parameter int N_SRC = 16,
  parameter int N_OUT = 8,
  parameter int REG_BYTES = 2,
  parameter int ADDR_W = 8,
  parameter logic [N_OUT-1:0] RESV_MASK = 8'b0000_0100,
  parameter logic [N_OUT-1:0] HARD_MASK = 8'b0010_0000,
  parameter logic [8*N_OUT-1:0] HARD_SRC = 64'h0000_0900_0000_0000,
  parameter int SAFE_SRC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_irq,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic [N_OUT-1:0]  out_irq
);
  localparam int SW = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int REG_BITS = 8 * REG_BYTES;

  function automatic int slot_of(int o);
    int k = 0;
    for (int i = 0; i < o; i++) if (!RESV_MASK[i]) k++;
    return k;
  endfunction

  logic [31:0] wr_val;
  logic        wr_ok;
  logic [N_OUT-1:0][SW-1:0] sel_view;
  logic [N_OUT-1:0][31:0]   rd_part;

  assign wr_val = 32'(wr_data[REG_BITS-1:0]);
  assign wr_ok  = wr_val < 32'(N_SRC);

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    localparam int OFF = REG_BYTES * slot_of(o);
    logic hit_r;
    assign hit_r = rd_addr == ADDR_W'(OFF);

    if (RESV_MASK[o]) begin : g_resv
      assign sel_view[o] = '0;
      assign out_irq[o]  = 1'b0;
      assign rd_part[o]  = '0;
    end else if (HARD_MASK[o]) begin : g_hard
      localparam int FIX = int'(HARD_SRC[8*o +: 8]);
      logic q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= 1'b0;
        else        q <= src_irq[FIX];
      assign sel_view[o] = SW'(FIX);
      assign out_irq[o]  = q;
      assign rd_part[o]  = hit_r ? 32'(FIX) : '0;
    end else begin : g_route
      logic [SW-1:0] sel;
      logic q, hit_w;
      assign hit_w = wr_en && (wr_addr == ADDR_W'(OFF)) && wr_ok;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          sel <= SW'(SAFE_SRC);
          q   <= 1'b0;
        end else begin
          if (hit_w) sel <= wr_val[SW-1:0];
          q <= src_irq[sel];
        end
      assign sel_view[o] = sel;
      assign out_irq[o]  = q;
      assign rd_part[o]  = hit_r ? 32'(sel) : '0;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int o = 0; o < N_OUT; o++) rd_data = rd_data | rd_part[o];
  end
endmodule

// File: rtl/irq_route_xbar_chk.sv
module irq_route_xbar_chk #(
  parameter int N_SRC = 16,
  parameter int N_OUT = 8,
  parameter int REG_BYTES = 2,
  parameter int ADDR_W = 8,
  parameter logic [N_OUT-1:0] RESV_MASK = 8'b0000_0100,
  parameter logic [N_OUT-1:0] HARD_MASK = 8'b0010_0000,
  parameter logic [8*N_OUT-1:0] HARD_SRC = 64'h0000_0900_0000_0000,
  parameter int SAFE_SRC = 3,
  parameter int SW = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_SRC-1:0]         src_irq,
  input logic                     wr_en,
  input logic [31:0]              wr_data,
  input logic [ADDR_W-1:0]        rd_addr,
  input logic [31:0]              rd_data,
  input logic [N_OUT-1:0]         out_irq,
  input logic [N_OUT-1:0][SW-1:0] sel_view
);
  localparam int REG_BITS = 8 * REG_BYTES;

  function automatic int live_count();
    int k = 0;
    for (int i = 0; i < N_OUT; i++) if (!RESV_MASK[i]) k++;
    return k;
  endfunction

  localparam int END_OFF = REG_BYTES * live_count();

  logic [31:0] wv;
  assign wv = 32'(wr_data[REG_BITS-1:0]);

  // R3
  resv_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_irq & RESV_MASK) == '0);

  // R6
  bad_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wv >= 32'(N_SRC)) |=> $stable(sel_view));

  // R7
  read_past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rd_addr) >= 32'(END_OFF)) |-> rd_data == '0);

  for (genvar o = 0; o < N_OUT; o++) begin : g_o
    if (!RESV_MASK[o] && HARD_MASK[o]) begin : g_h
      localparam int FIX = int'(HARD_SRC[8*o +: 8]);
      // R4
      hard_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_irq[o] == $past(src_irq[FIX]));
    end else if (!RESV_MASK[o]) begin : g_r
      // R1
      route_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_irq[o] == $past(src_irq[sel_view[o]]));
      // R5
      safe_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> sel_view[o] == SW'(SAFE_SRC));
    end
  end
endmodule

bind irq_route_xbar irq_route_xbar_chk #(
  .N_SRC(N_SRC), .N_OUT(N_OUT), .REG_BYTES(REG_BYTES), .ADDR_W(ADDR_W),
  .RESV_MASK(RESV_MASK), .HARD_MASK(HARD_MASK), .HARD_SRC(HARD_SRC),
  .SAFE_SRC(SAFE_SRC), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .wr_en(wr_en),
  .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
  .out_irq(out_irq), .sel_view(sel_view)
);

// File: tb/tb_irq_route_xbar.sv
module tb_irq_route_xbar;
  localparam int NS = 16, NO = 8, RB = 2, RESV = 2, HARD = 5, FIX = 9, SAFE = 3;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [NS-1:0] src_irq = '0;
  logic [7:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [NO-1:0] out_irq;

  int checks = 0, fails = 0;
  bit done = 0;
  int msel [NO];

  irq_route_xbar dut (.clk(clk), .rst_n(rst_n), .src_irq(src_irq), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .out_irq(out_irq));

  always #5 clk = ~clk;

  function automatic int off(int o);
    int k = 0;
    for (int i = 0; i < o; i++) if (i != RESV) k++;
    return RB * k;
  endfunction

  function automatic logic [NO-1:0] model(logic [NS-1:0] s);
    logic [NO-1:0] r = '0;
    for (int o = 0; o < NO; o++)
      if (o == HARD) r[o] = s[FIX];
      else if (o != RESV) r[o] = s[msel[o]];
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = 8'(a); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    rd_addr = 8'(a); #1; d = rd_data;
  endtask

  task automatic drive(logic [NS-1:0] s);
    @(negedge clk); src_irq = s;
    @(posedge clk); #1;
  endtask

  initial begin
    logic [31:0] v;
    for (int o = 0; o < NO; o++) msel[o] = SAFE;
    repeat (3) @(negedge clk);
    check("R1 reset low", 32'(out_irq), 0);
    rst_n = 1;
    @(negedge clk);

    for (int o = 0; o < NO; o++) begin
      if (o == RESV) continue;
      rd(off(o), v);
      check(o == HARD ? "R4 fixed read" : "R5 safe value", v, o == HARD ? FIX : SAFE);
    end
    drive(16'h0008);
    check("R5 safe route", 32'(out_irq), 32'(model(16'h0008)));

    // R1 R2 sweep over every routable output and source
    for (int o = 0; o < NO; o++) begin
      if (o == RESV || o == HARD) continue;
      for (int s = 0; s < NS; s++) begin
        wr(off(o), 32'(s)); msel[o] = s;
        rd(off(o), v);
        check("R2 readback", v, 32'(s));
        drive(NS'(1) << s);
        check("R1 onehot", 32'(out_irq), 32'(model(NS'(1) << s)));
        drive(~(NS'(1) << s));
        check("R1 complement", 32'(out_irq), 32'(model(~(NS'(1) << s))));
      end
    end

    // R2 compacted: offset 4 is output 3
    wr(4, 32'd11); msel[3] = 11;
    drive(16'h0800);
    check("R2 offset4 is out3", 32'(out_irq[3]), 1);

    // R6
    rd(off(0), v);
    wr(off(0), 32'd16);
    rd(off(0), v);
    check("R6 index 16 ignored", v, 32'(msel[0]));
    wr(off(0), 32'h0000_FFFF);
    rd(off(0), v);
    check("R6 index FFFF ignored", v, 32'(msel[0]));
    wr(off(0), 32'h0001_0006); msel[0] = 6;
    rd(off(0), v);
    check("R6 upper bits dropped", v, 6);

    // R4
    wr(off(HARD), 32'd1);
    rd(off(HARD), v);
    check("R4 write ignored", v, FIX);
    drive(16'h0200);
    check("R4 follows fixed", 32'(out_irq), 32'(model(16'h0200)));
    drive(16'hFDFF);
    check("R4 fixed low", 32'(out_irq[HARD]), 0);

    // R3
    drive(16'hFFFF);
    check("R3 reserved low", 32'(out_irq[RESV]), 0);
    check("R3 full vector", 32'(out_irq), 32'(model(16'hFFFF)));

    // R7
    rd(14, v); check("R7 end offset", v, 0);
    rd(15, v); check("R7 past end", v, 0);
    rd(254, v); check("R7 far offset", v, 0);
    rd(1, v);  check("R7 misaligned", v, 0);

    // R8: change lands only at next edge
    @(negedge clk); src_irq = '0; #1;
    check("R8 before edge", 32'(out_irq), 32'(model(16'hFFFF)));
    @(posedge clk); #1;
    check("R8 after edge", 32'(out_irq), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule